// File: doc/BRIEF.md
# Timer Match Output Action Unit

A free-running counter is compared against four compare registers. Each compare channel owns one persistent output bit that is driven straight to a pin. When the counter reaches a channel's compare value, the channel's 2-bit action code decides what happens to that bit. It can keep its value, be forced low, be forced high, or be inverted. The bit keeps its new level until the next match or until software writes it. The unit does not produce a one-cycle pulse.

Software reaches the unit through a single-cycle register port. The port gives access to the four compare registers, to an output/action register that holds the four output bits and their action codes, and to a read-only view of the counter. Read data appears one cycle after the request. A match fires once, on the first cycle in which the counter equals the compare value. The event does not repeat while the counter is stopped on that value.

Top module: `match_out_timer`

## Requirements
- R1: After reset the counter, all four compare registers, all output bits and all action codes are 0, and the pins are low.
- R2: Action code 00 leaves the channel's output bit unchanged on a match.
- R3: On a match, action code 01 forces the output bit to 0 and action code 10 forces it to 1.
- R4: On a match, action code 11 inverts the output bit.
- R5: In the output/action register (offset 4), output bit m sits at bit m. The action code of channel m sits at bits 2m+5:2m+4. Pin m equals output bit m in positive logic (1 = high).
- R6: Bits 31:12 of the output/action register read as 0. Writes to those bits are ignored.
- R7: A match is applied once per event, on the first cycle in which the counter equals the compare value. While the counter and the compare value stay equal, the action is not repeated.
- R8: The output bit changes at the clock edge where the counter value before that edge equals the compare value. Without a match or a write, the bit does not change.
- R9: A write to offset 4 loads bits 3:0 into the output bits directly. If a match with action 01, 10 or 11 hits a channel at the same edge, the match wins. The match uses the action code and output bit held before the write. The other channels take the written values.
- R10: The counter increments by one per cycle while `cnt_en` is high, holds while it is low, and wraps to 0 after its maximum value.
- R11: Offsets 0 to 3 hold the compare registers for channels 0 to 3. Offset 4 is the output/action register. Offset 5 is the counter, which is read-only, so writes to it are ignored. Other offsets read 0. Read data is valid on `rsp_rdata` in the cycle after the request and reflects the state before that request's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read request |
| match_pins | output | 4 | Output bits of the four channels |

## Verification
The checker assumes that `req_valid` and `req_we` are never X after reset. It also assumes that the event rule seen at the pins comes only from the counter and the stored compare values. For that reason the quiet-pin properties exempt any cycle that writes offset 4. The bench drives every input on the falling edge and issues one request per cycle. It creates match events in two ways: by letting the counter run, or by stopping it and writing a compare register to the current count. Each event therefore has a known edge. The same method exercises the case where a write and a match land together.

// File: rtl/match_out_timer.sv
module match_out_timer #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_en,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [2:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic [3:0]  match_pins
);
  localparam logic [2:0] ADDR_OUT = 3'd4;
  localparam logic [2:0] ADDR_CNT = 3'd5;

  logic [CNT_W-1:0]      cnt_q;
  logic [3:0][CNT_W-1:0] cmp_q;
  logic [3:0][1:0]       ctrl_q;
  logic [3:0]            out_q, out_nx, hit_q, eq, fire;

  wire wr     = req_valid & req_we;
  wire rd     = req_valid & ~req_we;
  wire out_wr = wr && (req_addr == ADDR_OUT);

  assign match_pins = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar m = 0; m < 4; m++) begin : g_ch
    assign eq[m]   = (cnt_q == cmp_q[m]);
    assign fire[m] = eq[m] & ~hit_q[m];

    always_comb begin
      out_nx[m] = out_wr ? req_wdata[m] : out_q[m];
      if (fire[m]) begin
        case (ctrl_q[m])
          2'b01:   out_nx[m] = 1'b0;
          2'b10:   out_nx[m] = 1'b1;
          2'b11:   out_nx[m] = ~out_q[m];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[m]  <= '0;
        ctrl_q[m] <= 2'b00;
        hit_q[m]  <= 1'b0;
      end else begin
        hit_q[m] <= eq[m];
        if (wr && req_addr == 3'(m)) cmp_q[m] <= req_wdata[CNT_W-1:0];
        if (out_wr) ctrl_q[m] <= req_wdata[2*m+5 -: 2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 4'b0;
    else out_q <= out_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (rd) begin
      case (req_addr)
        3'd0, 3'd1, 3'd2, 3'd3: rsp_rdata <= 32'(cmp_q[req_addr[1:0]]);
        ADDR_OUT: rsp_rdata <= {20'b0, ctrl_q, out_q};
        ADDR_CNT: rsp_rdata <= 32'(cnt_q);
        default:  rsp_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/match_out_timer_chk.sv
module match_out_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cnt_en,
  input logic                  req_valid,
  input logic                  req_we,
  input logic [2:0]            req_addr,
  input logic [31:0]           rsp_rdata,
  input logic [3:0]            match_pins,
  input logic [CNT_W-1:0]      cnt_q,
  input logic [3:0][CNT_W-1:0] cmp_q,
  input logic [3:0][1:0]       ctrl_q
);
  logic [3:0] seen_q, same;
  wire out_wr = req_valid && req_we && req_addr == 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 4'b0;
    else seen_q <= same;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (match_pins == 4'b0 && cnt_q == '0));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_addr == 3'd4) |=> rsp_rdata[31:12] == 20'b0);

  for (genvar m = 0; m < 4; m++) begin : g_ch
    assign same[m] = (cnt_q == cmp_q[m]);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!same[m] && !out_wr) |=> $stable(match_pins[m]));

    a_r7_once: assert property (@(posedge clk) disable iff (!rst_n)
      (same[m] && seen_q[m] && !out_wr) |=> $stable(match_pins[m]));

    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (same[m] && !seen_q[m] && ctrl_q[m] == 2'b11) |=> match_pins[m] != $past(match_pins[m]));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (same[m] && !seen_q[m] && ctrl_q[m] == 2'b01) |=> !match_pins[m]);

    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (same[m] && !seen_q[m] && ctrl_q[m] == 2'b10) |=> match_pins[m]);
  end
endmodule

bind match_out_timer match_out_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .req_valid(req_valid),
  .req_we(req_we), .req_addr(req_addr), .rsp_rdata(rsp_rdata),
  .match_pins(match_pins), .cnt_q(cnt_q), .cmp_q(cmp_q), .ctrl_q(ctrl_q)
);

// File: tb/sim_match_out_timer.sv
module sim_match_out_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [2:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0] match_pins;

  logic req_valid1 = 1'b0;
  logic [2:0] req_addr1 = '0;
  logic [31:0] rsp_rdata1;
  logic [3:0] match_pins1;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_out_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .match_pins(match_pins));

  match_out_timer #(.CNT_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_en(1'b1), .req_valid(req_valid1),
    .req_we(1'b0), .req_addr(req_addr1), .req_wdata(32'b0),
    .rsp_rdata(rsp_rdata1), .match_pins(match_pins1));

  // {chan[1:0], action[1:0], start bit, expected bit}
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'b00, 1'b1, 1'b1}, {2'd1, 2'b01, 1'b1, 1'b0},
    {2'd2, 2'b10, 1'b0, 1'b1}, {2'd3, 2'b11, 1'b0, 1'b1},
    {2'd3, 2'b11, 1'b1, 1'b0}, {2'd0, 2'b01, 1'b0, 1'b0},
    {2'd1, 2'b10, 1'b1, 1'b1}, {2'd2, 2'b00, 1'b0, 1'b0}};

  localparam logic [31:0] FAR = 32'd1000;
  localparam logic [31:0] STOP = 32'd21;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 wrap on a 4-bit counter: 17 edges -> 1
    repeat (17) @(negedge clk);
    req_valid1 = 1'b1; req_addr1 = 3'd5;
    @(negedge clk);
    req_valid1 = 1'b0;
    chk("R10 wrap", rsp_rdata1, 32'd1);

    // R1 reset state
    chk("R1 pins", {28'b0, match_pins}, 32'd0);
    rd(3'd4, v); chk("R1 out reg", v, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), v); chk("R1 compare", v, 32'd0);
    end
    rd(3'd5, v); chk("R1 counter", v, 32'd0);

    // R11 map: counter read-only, unused offset reads 0, readback
    wr(3'd5, 32'd123);
    rd(3'd5, v); chk("R11 counter write ignored", v, 32'd0);
    rd(3'd6, v); chk("R11 unused offset", v, 32'd0);
    wr(3'd1, 32'hDEADBEEF);
    rd(3'd1, v); chk("R11 compare readback", v, 32'hDEADBEEF);

    // R8 timing with running counter, R4 toggle on channel 0
    wr(3'd0, 32'd20);
    for (int i = 1; i < 4; i++) wr(3'(i), FAR);
    wr(3'd4, 32'h30);
    cnt_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 before match", {28'b0, match_pins}, 32'h0);
    @(negedge clk);
    chk("R8 at match", {28'b0, match_pins}, 32'h1);
    cnt_en = 1'b0;
    rd(3'd5, v); chk("R10 count value", v, STOP);

    // R7 event once while counter is stopped on the compare value
    wr(3'd0, STOP);
    @(negedge clk);
    chk("R4 toggle on stopped count", {28'b0, match_pins}, 32'h0);
    repeat (5) @(negedge clk);
    chk("R7 no repeat while stalled", {28'b0, match_pins}, 32'h0);
    wr(3'd0, FAR);

    // R2 R3 R4 R5 vector table
    foreach (VEC[i]) begin
      wr(3'd4, (32'(VEC[i][3:2]) << (4 + 2 * VEC[i][5:4])) | (32'(VEC[i][1]) << VEC[i][5:4]));
      wr(3'(VEC[i][5:4]), STOP);
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), {28'b0, match_pins},
          32'(VEC[i][0]) << VEC[i][5:4]);
      wr(3'(VEC[i][5:4]), FAR);
    end

    // R9 write and match at the same edge
    wr(3'd4, 32'h200);
    wr(3'd2, STOP);
    wr(3'd4, 32'h001);
    chk("R9 match beats write", {28'b0, match_pins}, 32'h5);
    rd(3'd4, v); chk("R9 register after clash", v, 32'h005);

    // R6 reserved bits
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R6 reserved read zero", v, 32'h0000_0FFF);
    chk("R5 pins follow bits", {28'b0, match_pins}, 32'hF);

    done = 1'b1;
    finish_run();
  end
endmodule